// File: doc/BRIEF.md
# ALU Control Decoder with Immediate Steering

This combinational unit turns the main controller's two-bit operation class, together with the instruction's six-bit function field and six-bit opcode, into the four-bit function code that drives the integer ALU. The opcode input extends the usual two-input arrangement. When the class is 11, immediate-format instructions choose their own ALU operation without help from the main controller.

The unit also shapes the 16-bit immediate into a full-width operand. It chooses between zero extension, sign extension and an upper-half placement, and it flags each choice on its outputs so the datapath can steer its operand muxes. For load-upper, the unit selects OR and asks the datapath to force the A operand to zero. The ALU result is then the immediate shifted up into the upper half, with the lower half cleared.

Top module: `alu_ctl_dec`

## Requirements
- R1: With `alu_op`=00, `alu_func` is add (0010), and `imm_zext`, `imm_upper` and `a_zero` are all 0.
- R2: With `alu_op`=01 (branch compare), `alu_func` is subtract (0110) for every value of `funct` and `opcode`.
- R3: With `alu_op`=10, `funct` selects the code: 0x20 gives add 0010, 0x22 gives subtract 0110, 0x24 gives AND 0000, 0x25 gives OR 0001, 0x27 gives NOR 1100 and 0x2A gives set-less-than 0111.
- R4: With `alu_op`=10, any `funct` not listed in R3 gives add (0010).
- R5: With `alu_op`=11, `opcode` selects the code: 0x08 gives add, 0x0A gives set-less-than, 0x0C gives AND and 0x0D gives OR. Any opcode that is neither one of these nor 0x0F gives add.
- R6: With `alu_op`=11 and `opcode` 0x0C or 0x0D, `imm_zext`=1 and `imm_op` is `imm_in` with zeros above it. With any other opcode except 0x0F, `imm_zext`=0 and `imm_op` is `imm_in` sign-extended.
- R7: With `alu_op`=11 and `opcode`=0x0F, `alu_func` is OR (0001), `a_zero`=1, `imm_upper`=1, `imm_zext`=0, and `imm_op` = `imm_in` shifted left by 16 with the low 16 bits zero.
- R8: With `alu_op`=11, `opcode`=0x0C and `imm_in`=0xFFFF, `imm_op` is 0x0000FFFF.
- R9: With `alu_op` other than 11, all three steering flags are 0 and `imm_op` is `imm_in` sign-extended.
- R10: `alu_func` is always one of the six codes listed in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_op | input | 2 | Operation class from the main controller |
| funct | input | 6 | Instruction function field |
| opcode | input | 6 | Instruction opcode field |
| imm_in | input | 16 | Raw immediate field |
| alu_func | output | 4 | ALU function code |
| imm_zext | output | 1 | Immediate is zero-extended |
| imm_upper | output | 1 | Immediate is placed in the upper half |
| a_zero | output | 1 | Datapath must force ALU operand A to zero |
| imm_op | output | 32 | Shaped immediate operand |

## Verification
The checker watches several properties whenever an input changes. It confirms that the memory and branch classes give add and subtract, that the steering flags stay clear outside class 11, that zero extension and upper placement agree with the bits of `imm_op`, that the two shaping flags are never set together, and that `alu_func` is one of the six legal codes. The exact mapping from each function field and opcode to its operation can only be shown by the bench. The bench sweeps every combination of class, function field and opcode against its own table. It also shows the default-to-add behaviour and the specific mask and load-upper values.

// File: rtl/alu_ctl_pkg.sv
package alu_ctl_pkg;
  localparam int FN_W  = 4;
  localparam int FLD_W = 6;

  typedef enum logic [FN_W-1:0] {
    FN_AND = 4'b0000,
    FN_OR  = 4'b0001,
    FN_ADD = 4'b0010,
    FN_SUB = 4'b0110,
    FN_SLT = 4'b0111,
    FN_NOR = 4'b1100
  } alu_fn_e;

  typedef enum logic [1:0] {
    CLS_MEM = 2'b00,
    CLS_BR  = 2'b01,
    CLS_REG = 2'b10,
    CLS_IMM = 2'b11
  } op_cls_e;

  // function field codes
  localparam logic [FLD_W-1:0] F_ADD = 6'h20;
  localparam logic [FLD_W-1:0] F_SUB = 6'h22;
  localparam logic [FLD_W-1:0] F_AND = 6'h24;
  localparam logic [FLD_W-1:0] F_OR  = 6'h25;
  localparam logic [FLD_W-1:0] F_NOR = 6'h27;
  localparam logic [FLD_W-1:0] F_SLT = 6'h2A;

  // immediate opcodes
  localparam logic [FLD_W-1:0] OP_ADDI = 6'h08;
  localparam logic [FLD_W-1:0] OP_SLTI = 6'h0A;
  localparam logic [FLD_W-1:0] OP_ANDI = 6'h0C;
  localparam logic [FLD_W-1:0] OP_ORI  = 6'h0D;
  localparam logic [FLD_W-1:0] OP_LUI  = 6'h0F;
endpackage

// File: rtl/alu_ctl_funct_dec.sv
module alu_ctl_funct_dec
  import alu_ctl_pkg::*;
(
  input  logic [FLD_W-1:0] funct,
  output alu_fn_e          fn
);
  always_comb begin
    unique case (funct)
      F_ADD:   fn = FN_ADD;
      F_SUB:   fn = FN_SUB;
      F_AND:   fn = FN_AND;
      F_OR:    fn = FN_OR;
      F_NOR:   fn = FN_NOR;
      F_SLT:   fn = FN_SLT;
      default: fn = FN_ADD;
    endcase
  end
endmodule

// File: rtl/alu_ctl_opc_dec.sv
module alu_ctl_opc_dec
  import alu_ctl_pkg::*;
(
  input  logic [FLD_W-1:0] opcode,
  output alu_fn_e          fn,
  output logic             zext,
  output logic             upper,
  output logic             a_zero
);
  always_comb begin
    fn     = FN_ADD;
    zext   = 1'b0;
    upper  = 1'b0;
    a_zero = 1'b0;
    unique case (opcode)
      OP_ADDI: fn = FN_ADD;
      OP_SLTI: fn = FN_SLT;
      OP_ANDI: begin fn = FN_AND; zext = 1'b1; end
      OP_ORI:  begin fn = FN_OR;  zext = 1'b1; end
      OP_LUI:  begin fn = FN_OR;  upper = 1'b1; a_zero = 1'b1; end
      default: fn = FN_ADD;
    endcase
  end
endmodule

// File: rtl/alu_ctl_imm_shape.sv
module alu_ctl_imm_shape #(
  parameter int IMM_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic              zext,
  input  logic              upper,
  output logic [DATA_W-1:0] op
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] z_val, s_val, u_val;

  assign z_val = {{PAD_W{1'b0}}, imm};
  assign s_val = {{PAD_W{imm[IMM_W-1]}}, imm};
  assign u_val = z_val << IMM_W;

  always_comb begin
    if (upper)     op = u_val;
    else if (zext) op = z_val;
    else           op = s_val;
  end
endmodule

// File: rtl/alu_ctl_dec.sv
module alu_ctl_dec
  import alu_ctl_pkg::*;
#(
  parameter int IMM_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic [1:0]        alu_op,
  input  logic [5:0]        funct,
  input  logic [5:0]        opcode,
  input  logic [IMM_W-1:0]  imm_in,
  output logic [3:0]        alu_func,
  output logic              imm_zext,
  output logic              imm_upper,
  output logic              a_zero,
  output logic [DATA_W-1:0] imm_op
);
  alu_fn_e reg_fn, imm_fn;
  logic    o_zext, o_upper, o_azero;
  logic    is_imm;

  alu_ctl_funct_dec u_fdec (.funct(funct), .fn(reg_fn));

  alu_ctl_opc_dec u_odec (
    .opcode(opcode), .fn(imm_fn), .zext(o_zext),
    .upper(o_upper), .a_zero(o_azero)
  );

  assign is_imm = (op_cls_e'(alu_op) == CLS_IMM);

  always_comb begin
    unique case (op_cls_e'(alu_op))
      CLS_MEM: alu_func = FN_ADD;
      CLS_BR:  alu_func = FN_SUB;
      CLS_REG: alu_func = reg_fn;
      default: alu_func = imm_fn;
    endcase
  end

  assign imm_zext  = is_imm & o_zext;
  assign imm_upper = is_imm & o_upper;
  assign a_zero    = is_imm & o_azero;

  alu_ctl_imm_shape #(.IMM_W(IMM_W), .DATA_W(DATA_W)) u_shape (
    .imm(imm_in), .zext(imm_zext), .upper(imm_upper), .op(imm_op)
  );
endmodule

// File: rtl/alu_ctl_dec_chk.sv
module alu_ctl_dec_chk #(
  parameter int IMM_W  = 16,
  parameter int DATA_W = 32
) (
  input logic [1:0]        alu_op,
  input logic [IMM_W-1:0]  imm_in,
  input logic [3:0]        alu_func,
  input logic              imm_zext,
  input logic              imm_upper,
  input logic              a_zero,
  input logic [DATA_W-1:0] imm_op
);
  always_comb begin
    AST_MEM_ADD: assert (alu_op != 2'b00 || alu_func == 4'b0010) else $error("mem class not add"); // R1
    AST_BR_SUB: assert (alu_op != 2'b01 || alu_func == 4'b0110) else $error("branch not sub"); // R2
    AST_FLAGS_IDLE: assert (alu_op == 2'b11 || !(imm_zext || imm_upper || a_zero)) else $error("flags set"); // R9
    AST_ZEXT_HIGH: assert (!imm_zext || (imm_op[DATA_W-1:IMM_W] == '0 && imm_op[IMM_W-1:0] == imm_in)) else $error("zext shape"); // R6
    AST_UPPER_LOW: assert (!imm_upper || (imm_op[IMM_W-1:0] == '0 && a_zero)) else $error("upper shape"); // R7
    AST_ONE_SHAPE: assert (!(imm_zext && imm_upper)) else $error("two shapes"); // R7
    AST_LEGAL_FN: assert (alu_func inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100}) else $error("bad code"); // R10
  end
endmodule

bind alu_ctl_dec alu_ctl_dec_chk #(.IMM_W(IMM_W), .DATA_W(DATA_W)) chk_i (
  .alu_op(alu_op), .imm_in(imm_in), .alu_func(alu_func), .imm_zext(imm_zext),
  .imm_upper(imm_upper), .a_zero(a_zero), .imm_op(imm_op)
);

// File: tb/alu_ctl_dec_tb.sv
`timescale 1ns/1ps
module alu_ctl_dec_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]  alu_op = '0;
  logic [5:0]  funct = '0, opcode = '0;
  logic [15:0] imm_in = '0;
  logic [3:0]  alu_func;
  logic        imm_zext, imm_upper, a_zero;
  logic [31:0] imm_op;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  alu_ctl_dec dut_i (
    .alu_op(alu_op), .funct(funct), .opcode(opcode), .imm_in(imm_in),
    .alu_func(alu_func), .imm_zext(imm_zext), .imm_upper(imm_upper),
    .a_zero(a_zero), .imm_op(imm_op)
  );

  function automatic logic [3:0] fn_of_funct(logic [5:0] f);
    if (f == 6'h20) return 4'b0010;
    if (f == 6'h22) return 4'b0110;
    if (f == 6'h24) return 4'b0000;
    if (f == 6'h25) return 4'b0001;
    if (f == 6'h27) return 4'b1100;
    if (f == 6'h2A) return 4'b0111;
    return 4'b0010;
  endfunction

  function automatic logic [3:0] fn_of_opc(logic [5:0] o);
    if (o == 6'h0A) return 4'b0111;
    if (o == 6'h0C) return 4'b0000;
    if (o == 6'h0D || o == 6'h0F) return 4'b0001;
    return 4'b0010;
  endfunction

  task automatic check(string tag, logic [39:0] act, logic [39:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%b fn=%h opc=%h imm=%h act=%h exp=%h",
               tag, alu_op, funct, opcode, imm_in, act, exp);
    end
  endtask

  task automatic apply(logic [1:0] c, logic [5:0] f, logic [5:0] o, logic [15:0] i);
    @(posedge clk);
    alu_op = c; funct = f; opcode = o; imm_in = i;
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: idle inputs give add with flags clear
    check("R1 idle", {alu_func, imm_zext, imm_upper, a_zero, 32'h0}, {4'b0010, 3'b000, 32'h0});

    for (int c = 0; c < 4; c++) begin
      for (int o = 0; o < 64; o++) begin
        for (int f = 0; f < 64; f++) begin
          logic [15:0] im;
          logic [3:0]  ef;
          logic        ez, eu, ea;
          logic [31:0] eo;
          string       tg;
          im = 16'((o * 1103 + f * 977 + c * 40503) & 16'hFFFF);
          apply(2'(c), 6'(f), 6'(o), im);
          ez = 0; eu = 0; ea = 0;
          case (c)
            0: begin ef = 4'b0010; tg = "R1"; end
            1: begin ef = 4'b0110; tg = "R2"; end
            2: begin ef = fn_of_funct(6'(f)); tg = (ef == 4'b0010 && f != 32) ? "R4" : "R3"; end
            default: begin
              ef = fn_of_opc(6'(o));
              tg = (o == 15) ? "R7" : "R5";
              ez = (o == 12 || o == 13);
              eu = (o == 15);
              ea = eu;
            end
          endcase
          if (eu)      eo = {im, 16'h0000};
          else if (ez) eo = {16'h0000, im};
          else         eo = {{16{im[15]}}, im};
          check(tg, {alu_func, 36'h0}, {ef, 36'h0});
          check((c == 3) ? "R6" : "R9", {imm_zext, imm_upper, a_zero, imm_op, 5'h0},
                {ez, eu, ea, eo, 5'h0});
        end
      end
    end

    // R8: mask with andi and all-ones immediate
    apply(2'b11, 6'h00, 6'h0C, 16'hFFFF);
    check("R8", {8'h0, imm_op}, {8'h0, 32'h0000FFFF});
    // R6: negative immediate on addi sign-extends
    apply(2'b11, 6'h00, 6'h08, 16'hFFFC);
    check("R6", {imm_zext, 7'h0, imm_op}, {1'b0, 7'h0, 32'hFFFFFFFC});
    // R7: load-upper with high bit set
    apply(2'b11, 6'h2A, 6'h0F, 16'h8001);
    check("R7", {alu_func, a_zero, 3'h0, imm_op}, {4'b0001, 1'b1, 3'h0, 32'h80010000});
    // R10: every code seen so far is legal
    check("R10", {39'h0, alu_func inside {4'h0, 4'h1, 4'h2, 4'h6, 4'h7, 4'hC}}, 40'h1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule